// File: doc/BRIEF.md
# Burst-Synchronized Symbol Overlay Generator

This block makes one pseudo-random overlay bit for each data symbol and XORs it onto the symbol's data bits. On the transmit side this whitens the spectrum of repetitive data. On the receive side the same operation removes the overlay again. The bit comes from a shift-register sequence of maximal length. A two-bit select field picks one of three lengths or turns the overlay off.

The sequence restarts from a fixed seed at every burst-start pulse. A transmitter and a receiver that both see the burst boundary therefore stay aligned without any other handshake. The register advances on a symbol strobe, once per symbol, and never per chip.

In QPSK mode the in-phase and quadrature bits of a symbol share one overlay bit. In BPSK mode only the in-phase lane is overlaid.

Top module: `sym_overlay`

## Requirements
- R1: While reset is asserted, and after it until the first burst start, the overlay is off: `ovlBit` is 0 and `dataOut` equals `dataIn`.
- R2: A burst started with select 0 disables the overlay. `ovlBit` stays 0 and `dataOut` equals `dataIn` on every lane, whatever the strobes do.
- R3: With select 1 the overlay bits of a burst are b[k]. For k below 6, b[k]=1. After that, b[k]=b[k-2]^b[k-3]^b[k-5]^b[k-6]. The sequence repeats after exactly 63 symbols and after no shorter period.
- R4: Select 2 uses the same rule with the last term b[k-9], and the first 9 bits are 1. The period is exactly 511.
- R5: Select 3 uses the same rule with the last term b[k-10], and the first 10 bits are 1. The period is exactly 1023.
- R6: A burst-start pulse restarts the sequence. On the cycle after the pulse, `ovlBit` shows b[0]=1 for any nonzero select, even in the middle of a burst.
- R7: The sequence index moves forward by one only on a clock edge where `symStep` is high. Without a step, `ovlBit` holds its value.
- R8: `codeSel` is sampled only on a burst-start edge. Changes between bursts do not affect the running sequence.
- R9: When `qpskMode` is 1, every lane gives dataOut[i]=dataIn[i]^ovlBit. When `qpskMode` is 0, only lane 0 is XORed and lane 1 passes through unchanged. Lane 0 is I and lane 1 is Q.
- R10: If `burstStart` and `symStep` arrive on the same edge, the restart wins. The next cycle shows b[0], and the step is not applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| burstStart | input | 1 | One-cycle pulse at the start of a burst; reloads the seed and samples `codeSel` |
| symStep | input | 1 | Advances the sequence by one symbol |
| codeSel | input | 2 | 0 off, 1 length 63, 2 length 511, 3 length 1023 |
| qpskMode | input | 1 | 1 applies the overlay to both lanes, 0 to lane 0 only |
| dataIn | input | LANES | Symbol data bits, lane 0 = I, lane 1 = Q |
| dataOut | output | LANES | Data with the overlay applied or removed |
| ovlBit | output | 1 | Overlay bit for the current symbol |

## Verification
The hardest thing to show from the ports is minimal period: that the 1023-symbol sequence never repeats at any shorter spacing. The bench starts a burst for each select and records twice the sequence length of `ovlBit` values. It then checks two things. The recording must match itself at a shift of one full period. It must also differ somewhere at every shift of period divided by a prime factor. Mid-burst restarts, select changes between bursts, idle gaps and a restart that collides with a step are placed inside these sweeps. Each of these must leave the recorded sequence in the expected position.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int REG_W = 10;

  typedef enum logic [1:0] {
    SEL_OFF   = 2'd0,
    SEL_L63   = 2'd1,
    SEL_L511  = 2'd2,
    SEL_L1023 = 2'd3
  } ovlSel_e;

  typedef struct packed {
    logic    seedLoad;
    logic    shiftEn;
    ovlSel_e seedSel;
  } ovlStrobe_t;

  function automatic int unsigned degreeOf(ovlSel_e s);
    case (s)
      SEL_L63:  return 6;
      SEL_L511: return 9;
      default:  return 10;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] seedFor(ovlSel_e s);
    logic [REG_W-1:0] m;
    for (int i = 0; i < REG_W; i++) m[i] = (i < int'(degreeOf(s)));
    return m;
  endfunction
endpackage

// File: rtl/ovl_ctrl.sv
module ovl_ctrl
  import ovl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       burstStart,
  input  logic       symStep,
  input  ovlSel_e    selIn,
  output ovlStrobe_t strobe,
  output ovlSel_e    activeSel
);
  // select is captured only at a burst boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           activeSel <= SEL_OFF;
    else if (burstStart) activeSel <= selIn;
  end

  // restart has priority over a step on the same edge
  always_comb begin
    strobe.seedLoad = burstStart;
    strobe.seedSel  = selIn;
    strobe.shiftEn  = symStep && !burstStart && (activeSel != SEL_OFF);
  end
endmodule

// File: rtl/ovl_datapath.sv
module ovl_datapath
  import ovl_pkg::*;
#(
  parameter int LANES = 2
)(
  input  logic             clk,
  input  logic             rstN,
  input  ovlStrobe_t       strobe,
  input  ovlSel_e          activeSel,
  input  logic             qpskMode,
  input  logic [LANES-1:0] dataIn,
  output logic [LANES-1:0] dataOut,
  output logic             ovlBit
);
  logic [REG_W-1:0] shiftReg;
  logic             tailBit;
  logic             feedback;

  // the oldest bit sits at position degree-1 for the active length
  always_comb begin
    case (activeSel)
      SEL_L63:  tailBit = shiftReg[5];
      SEL_L511: tailBit = shiftReg[8];
      default:  tailBit = shiftReg[REG_W-1];
    endcase
    feedback = shiftReg[1] ^ shiftReg[2] ^ shiftReg[4] ^ tailBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      shiftReg <= seedFor(SEL_L1023);
    else if (strobe.seedLoad)
      shiftReg <= seedFor(strobe.seedSel);
    else if (strobe.shiftEn)
      shiftReg <= {shiftReg[REG_W-2:0], feedback} & seedFor(activeSel);
  end

  assign ovlBit = (activeSel != SEL_OFF) && tailBit;

  // lane 0 is always overlaid, the other lanes only in QPSK mode
  for (genvar g = 0; g < LANES; g++) begin : gLane
    if (g == 0) begin : gFirst
      assign dataOut[g] = dataIn[g] ^ ovlBit;
    end else begin : gRest
      assign dataOut[g] = dataIn[g] ^ (ovlBit & qpskMode);
    end
  end
endmodule

// File: rtl/sym_overlay.sv
module sym_overlay
  import ovl_pkg::*;
#(
  parameter int LANES = 2
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             burstStart,
  input  logic             symStep,
  input  logic [1:0]       codeSel,
  input  logic             qpskMode,
  input  logic [LANES-1:0] dataIn,
  output logic [LANES-1:0] dataOut,
  output logic             ovlBit
);
  ovlStrobe_t strobe;
  ovlSel_e    activeSel;

  ovl_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .burstStart (burstStart),
    .symStep    (symStep),
    .selIn      (ovlSel_e'(codeSel)),
    .strobe     (strobe),
    .activeSel  (activeSel)
  );

  ovl_datapath #(.LANES(LANES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .activeSel (activeSel),
    .qpskMode  (qpskMode),
    .dataIn    (dataIn),
    .dataOut   (dataOut),
    .ovlBit    (ovlBit)
  );
endmodule

// File: rtl/sym_overlay_chk.sv
module sym_overlay_chk #(
  parameter int LANES = 2
)(
  input logic             clk,
  input logic             rstN,
  input logic             burstStart,
  input logic             symStep,
  input logic [1:0]       codeSel,
  input logic             qpskMode,
  input logic [LANES-1:0] dataIn,
  input logic [LANES-1:0] dataOut,
  input logic             ovlBit,
  input logic [1:0]       activeSel
);
  always @(negedge clk) begin
    if (!rstN) begin
      a_r1_reset_off: assert (ovlBit == 1'b0 && dataOut == dataIn);
    end
  end

  a_r2_off_passes: assert property (@(posedge clk) disable iff (!rstN)
    (activeSel == 2'd0) |-> (ovlBit == 1'b0 && dataOut == dataIn));

  a_r6_seed_first: assert property (@(posedge clk) disable iff (!rstN)
    (burstStart && codeSel != 2'd0) |=> ovlBit);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!symStep && !burstStart) |=> $stable(ovlBit));

  a_r8_sel_held: assert property (@(posedge clk) disable iff (!rstN)
    !burstStart |=> $stable(activeSel));

  a_r9_qpsk_both: assert property (@(posedge clk) disable iff (!rstN)
    qpskMode |-> (dataOut == (dataIn ^ {LANES{ovlBit}})));

  a_r9_bpsk_q_clear: assert property (@(posedge clk) disable iff (!rstN)
    !qpskMode |-> (dataOut[LANES-1:1] == dataIn[LANES-1:1]));

  a_r10_restart_wins: assert property (@(posedge clk) disable iff (!rstN)
    (burstStart && symStep && codeSel != 2'd0) |=> ovlBit);
endmodule

bind sym_overlay sym_overlay_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .burstStart (burstStart),
  .symStep    (symStep),
  .codeSel    (codeSel),
  .qpskMode   (qpskMode),
  .dataIn     (dataIn),
  .dataOut    (dataOut),
  .ovlBit     (ovlBit),
  .activeSel  (activeSel)
);

// File: tb/sym_overlay_test.sv
`timescale 1ns/1ps
module sym_overlay_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       burstStart = 1'b0;
  logic       symStep = 1'b0;
  logic [1:0] codeSel = 2'd0;
  logic       qpskMode = 1'b0;
  logic [1:0] dataIn = 2'd0;
  logic [1:0] dataOut;
  logic       ovlBit;

  int total = 0;
  int bad = 0;
  bit refSeq [0:2047];
  bit seen   [0:2047];

  always #2.5 clk = ~clk;

  sym_overlay #(.LANES(2)) uut (
    .clk(clk), .rstN(rstN), .burstStart(burstStart), .symStep(symStep),
    .codeSel(codeSel), .qpskMode(qpskMode), .dataIn(dataIn),
    .dataOut(dataOut), .ovlBit(ovlBit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lenOf(input int sel);
    return (sel == 1) ? 63 : (sel == 2) ? 511 : 1023;
  endfunction

  function automatic int degOf(input int sel);
    return (sel == 1) ? 6 : (sel == 2) ? 9 : 10;
  endfunction

  task automatic buildRef(input int sel);
    int d = degOf(sel);
    for (int k = 0; k < 2048; k++)
      refSeq[k] = (k < d) ? 1'b1 : (refSeq[k-2] ^ refSeq[k-3] ^ refSeq[k-5] ^ refSeq[k-d]);
  endtask

  task automatic pulseBurst(input int sel, input bit withStep);
    codeSel = sel[1:0];
    burstStart = 1'b1;
    symStep = withStep;
    @(negedge clk);
    burstStart = 1'b0;
    symStep = 1'b0;
  endtask

  task automatic stepOnce();
    symStep = 1'b1;
    @(negedge clk);
    symStep = 1'b0;
  endtask

  // check design bit k against the model and record it
  task automatic checkBit(input int k, input string req);
    seen[k] = ovlBit;
    check(ovlBit == refSeq[k], req, ovlBit, refSeq[k]);
  endtask

  task automatic sweep(input int sel, input string req);
    int len = lenOf(sel);
    int divs[3];
    buildRef(sel);
    pulseBurst(sel, 1'b0);
    for (int k = 0; k < 2 * len; k++) begin
      qpskMode = k[2];
      dataIn = k[1:0];
      #1;
      checkBit(k, req);
      if (qpskMode)
        check(dataOut == (dataIn ^ {2{refSeq[k]}}), "R9", dataOut, dataIn ^ {2{refSeq[k]}});
      else
        check(dataOut == {dataIn[1], dataIn[0] ^ refSeq[k]}, "R9", dataOut, {dataIn[1], dataIn[0] ^ refSeq[k]});
      @(negedge clk);
      stepOnce();
    end
    // exact repeat after one period
    begin
      int mism = 0;
      for (int k = 0; k < len; k++) if (seen[k] != seen[k+len]) mism++;
      check(mism == 0, req, mism, 0);
    end
    // no shorter period: shifts by period / prime factor must differ
    if (sel == 1) divs = '{21, 9, 9};
    else if (sel == 2) divs = '{73, 7, 7};
    else divs = '{341, 93, 33};
    for (int j = 0; j < 3; j++) begin
      int diff = 0;
      for (int k = 0; k < len; k++) if (seen[k] != seen[k+divs[j]]) diff++;
      check(diff != 0, req, diff, 1);
    end
  endtask

  initial begin : watchdog
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    for (int v = 0; v < 4; v++) begin
      dataIn = v[1:0];
      qpskMode = v[0];
      #1;
      check(ovlBit == 1'b0, "R1", ovlBit, 0);
      check(dataOut == dataIn, "R1", dataOut, dataIn);
      @(negedge clk);
    end
    rstN = 1'b1;
    @(negedge clk);
    stepOnce();
    qpskMode = 1'b1;
    dataIn = 2'b11;
    #1;
    check(dataOut == 2'b11, "R1", dataOut, 3);
    @(negedge clk);

    // R2: select 0 passes data, strobes have no effect
    pulseBurst(0, 1'b0);
    for (int v = 0; v < 8; v++) begin
      qpskMode = v[2];
      dataIn = v[1:0];
      #1;
      check(ovlBit == 1'b0, "R2", ovlBit, 0);
      check(dataOut == dataIn, "R2", dataOut, dataIn);
      @(negedge clk);
      stepOnce();
    end

    sweep(1, "R3");
    sweep(2, "R4");
    sweep(3, "R5");

    // R6: mid-burst restart with select 1
    buildRef(1);
    pulseBurst(1, 1'b0);
    for (int k = 0; k < 20; k++) stepOnce();
    pulseBurst(1, 1'b0);
    for (int k = 0; k < 30; k++) begin
      #1;
      checkBit(k, "R6");
      @(negedge clk);
      stepOnce();
    end

    // R7: idle gaps do not advance the sequence
    pulseBurst(1, 1'b0);
    for (int k = 0; k < 40; k++) begin
      repeat (k % 4) @(negedge clk);
      #1;
      checkBit(k, "R7");
      @(negedge clk);
      stepOnce();
    end

    // R8: select changed mid-burst is ignored until the next restart
    pulseBurst(1, 1'b0);
    codeSel = 2'd3;
    for (int k = 0; k < 70; k++) begin
      #1;
      checkBit(k, "R8");
      @(negedge clk);
      stepOnce();
    end
    buildRef(3);
    pulseBurst(3, 1'b0);
    codeSel = 2'd0;
    for (int k = 0; k < 30; k++) begin
      #1;
      checkBit(k, "R8");
      @(negedge clk);
      stepOnce();
    end

    // R10: restart colliding with a step
    buildRef(2);
    pulseBurst(2, 1'b0);
    for (int k = 0; k < 15; k++) stepOnce();
    pulseBurst(2, 1'b1);
    for (int k = 0; k < 25; k++) begin
      #1;
      checkBit(k, "R10");
      @(negedge clk);
      stepOnce();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule